// File: doc/BRIEF.md
# Serial Port Register Block with Watermark Interrupts

This block is the bus side of a simple serial port. A host issues 32-bit word reads and writes with a byte-enable mask. The block keeps a small receive FIFO that is filled from a valid/ready byte-stream input. A write to the transmit-data register sends its low byte out as a one-cycle pulse on a byte-stream output.

Control, interrupt-enable and divisor registers store and return what was written. The divisor is only stored; no baud generator uses it. A read-only pending register reports two watermark conditions. A single level interrupt line is driven from the enables and the receive FIFO occupancy. The bit-level serializer, the deserializer and any transmit queue sit outside this block.

A request is presented for one cycle. The read response appears on `rsp_rdata` with `rsp_valid` one cycle later. `rsp_rdata` is zero in every cycle that does not follow an accepted read.

Top module: `uart_regblock`

## Requirements
- R1: A full read of the receive-data register (byte offset 0x04) while the FIFO holds data returns the oldest byte in bits [7:0], with bits [31:8] zero, one cycle later, and removes that byte from the FIFO.
- R2: A full read of offset 0x04 while the FIFO is empty returns 0x80000000 (bit 31 flags empty) and leaves the FIFO unchanged.
- R3: A full write to the transmit-data register (offset 0x00) raises `tx_valid` for exactly the next cycle with `tx_data` equal to bits [7:0] of the written word. A read of offset 0x00 returns 0.
- R4: Pending bit 1 (pending register at offset 0x14) is 1 exactly when the FIFO occupancy is strictly greater than bits [18:16] of the receive-control register (offset 0x0C).
- R5: Pending bit 0 is 1 exactly when bits [18:16] of the transmit-control register (offset 0x08) are nonzero.
- R6: After each clock edge, `irq` equals enable bit 0 OR (enable bit 1 AND FIFO not empty), where the enable register is at offset 0x10 and both terms reflect the state after that edge.
- R7: The enable (0x10), transmit-control (0x08), receive-control (0x0C) and divisor (0x18) registers read back exactly the full 32-bit value last written.
- R8: While the FIFO holds DEPTH bytes (8 by default), `rx_ready` is low and an offered byte is dropped. Bytes already stored are kept in order.
- R9: An access with `req_be` other than 4'b1111 has no effect: a read returns 0 and does not pop, and a write changes nothing. A read of an unmapped offset (0x1C) returns 0, and a write to it is ignored.
- R10: A pop caused by a receive-data read and a push from the input in the same cycle both take effect. The popped byte is the previous oldest byte, and the pushed byte joins the tail.
- R11: After reset, every register reads 0, the FIFO is empty, `rx_ready` is 1, and `irq` and `tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits [ADDR_W-1:2] select the register |
| req_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 32 | Read data |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | FIFO can take a byte |
| tx_valid | output | 1 | Outgoing byte pulse |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that a stalled input byte is offered while no bus request is in flight. They also assume that an empty-FIFO read is not paired with a push in the same cycle, so that occupancy can be compared across one edge. Each bench task drives at most one bus request per cycle on the falling edge. The bench offers bytes only on their own cycles, except in the single test that deliberately pairs a pop with a push. It samples every output on the falling edge after the capturing rising edge.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned WM_LSB   = 16;
  localparam int unsigned WM_W     = 3;
  localparam int unsigned EN_TX    = 0;
  localparam int unsigned EN_RX    = 1;
  localparam logic [DATA_W-1:0] RX_EMPTY_WORD = 32'h8000_0000;

  // word index of each register (byte offset / 4)
  typedef enum logic [2:0] {
    IDX_TXD  = 3'd0,
    IDX_RXD  = 3'd1,
    IDX_TXC  = 3'd2,
    IDX_RXC  = 3'd3,
    IDX_IE   = 3'd4,
    IDX_IP   = 3'd5,
    IDX_DIV  = 3'd6,
    IDX_NONE = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/uart_rb_fifo.sv
module uart_rb_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic [CW-1:0]    count_nxt,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_comb begin
    count_nxt = count;
    if (push_ok && !pop_ok)      count_nxt = count + 1'b1;
    else if (pop_ok && !push_ok) count_nxt = count - 1'b1;
  end

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count <= count_nxt;
    end
  end
endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq #(
  parameter int unsigned CW   = 4,
  parameter int unsigned WM_W = 3
) (
  input  logic [WM_W-1:0] tx_mark,
  input  logic [WM_W-1:0] rx_mark,
  input  logic [CW-1:0]   occ,
  input  logic            en_tx_nxt,
  input  logic            en_rx_nxt,
  input  logic [CW-1:0]   occ_nxt,
  output logic [1:0]      pend,
  output logic            irq_nxt
);
  always_comb begin
    pend[0] = (tx_mark != '0);
    pend[1] = (32'(occ) > 32'(rx_mark));
    irq_nxt = en_tx_nxt || (en_rx_nxt && (occ_nxt != '0));
  end
endmodule

// File: rtl/uart_regblock.sv
module uart_regblock
  import uart_rb_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned IW = ADDR_W - 2,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);
  logic [IW-1:0]     idx;
  logic              acc, wr_en, rd_en, pop;
  logic [DATA_W-1:0] ie_q, txc_q, rxc_q, div_q, ie_nxt;
  logic [DATA_W-1:0] rd_word;
  logic [BYTE_W-1:0] head;
  logic [CW-1:0]     occ, occ_nxt;
  logic              full, empty;
  logic [1:0]        pend;
  logic              irq_nxt;

  assign idx   = req_addr[ADDR_W-1:2];
  assign acc   = req_valid && (req_be == 4'hF);
  assign wr_en = acc && req_write;
  assign rd_en = acc && !req_write;
  assign pop   = rd_en && (idx == IW'(IDX_RXD));

  assign rx_ready = !full;

  uart_rb_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_fifo (
    .clk(clk), .rst(rst),
    .push(rx_valid), .push_data(rx_data),
    .pop(pop), .head(head),
    .count(occ), .count_nxt(occ_nxt),
    .full(full), .empty(empty)
  );

  assign ie_nxt = (wr_en && idx == IW'(IDX_IE)) ? req_wdata : ie_q;

  uart_rb_irq #(.CW(CW), .WM_W(WM_W)) u_irq (
    .tx_mark(txc_q[WM_LSB +: WM_W]),
    .rx_mark(rxc_q[WM_LSB +: WM_W]),
    .occ(occ),
    .en_tx_nxt(ie_nxt[EN_TX]),
    .en_rx_nxt(ie_nxt[EN_RX]),
    .occ_nxt(occ_nxt),
    .pend(pend),
    .irq_nxt(irq_nxt)
  );

  always_comb begin
    rd_word = '0;
    if (idx == IW'(IDX_RXD))      rd_word = empty ? RX_EMPTY_WORD : DATA_W'(head);
    else if (idx == IW'(IDX_TXC)) rd_word = txc_q;
    else if (idx == IW'(IDX_RXC)) rd_word = rxc_q;
    else if (idx == IW'(IDX_IE))  rd_word = ie_q;
    else if (idx == IW'(IDX_IP))  rd_word = DATA_W'(pend);
    else if (idx == IW'(IDX_DIV)) rd_word = div_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q      <= '0;
      txc_q     <= '0;
      rxc_q     <= '0;
      div_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      irq       <= 1'b0;
    end else begin
      ie_q      <= ie_nxt;
      if (wr_en && idx == IW'(IDX_TXC)) txc_q <= req_wdata;
      if (wr_en && idx == IW'(IDX_RXC)) rxc_q <= req_wdata;
      if (wr_en && idx == IW'(IDX_DIV)) div_q <= req_wdata;
      rsp_valid <= rd_en;
      rsp_rdata <= rd_en ? rd_word : '0;
      tx_valid  <= wr_en && (idx == IW'(IDX_TXD));
      tx_data   <= (wr_en && idx == IW'(IDX_TXD)) ? req_wdata[7:0] : tx_data;
      irq       <= irq_nxt;
    end
  end
endmodule

// File: rtl/uart_regblock_chk.sv
module uart_regblock_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CW     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_be,
  input logic [31:0]       req_wdata,
  input logic [31:0]       rsp_rdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic [CW-1:0]     occ
);
  logic full_acc, tx_wr, rx_rd;
  assign full_acc = req_valid && (req_be == 4'hF);
  assign tx_wr    = full_acc && req_write && (req_addr[ADDR_W-1:2] == '0);
  assign rx_rd    = full_acc && !req_write && (req_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    32'(occ) <= DEPTH); // R8

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready && !req_valid) |=> occ == $past(occ)); // R8

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && occ == '0 && !rx_valid) |=> (rsp_rdata == 32'h8000_0000) && (occ == '0)); // R2

  AST_TX_BYTE: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> tx_valid && (tx_data == $past(req_wdata[7:0]))); // R3

  AST_TX_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tx_wr |=> !tx_valid); // R3

  AST_PARTIAL_NOP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_be != 4'hF && !rx_valid) |=> (rsp_rdata == '0) && (occ == $past(occ))); // R9
endmodule

bind uart_regblock uart_regblock_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
  .rsp_rdata(rsp_rdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_data(tx_data), .occ(occ)
);

// File: tb/uart_regblock_tb.sv
`timescale 1ns/1ps
module uart_regblock_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [4:0]  req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready, tx_valid;
  logic [7:0]  tx_data;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;

  localparam logic [4:0] A_TXD = 5'h00, A_RXD = 5'h04, A_TXC = 5'h08,
                         A_RXC = 5'h0C, A_IE = 5'h10, A_IP = 5'h14,
                         A_DIV = 5'h18, A_BAD = 5'h1C;

  always #10 clk = ~clk;

  uart_regblock u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    req_valid = 0; req_write = 0; req_addr = '0; req_be = 4'hF; req_wdata = '0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    idle_bus();
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_be = be;
    @(negedge clk);
    d = rsp_rdata;
    idle_bus();
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R11 rx_ready", 32'(rx_ready), 1);
    chk("R11 irq", 32'(irq), 0);
    chk("R11 tx_valid", 32'(tx_valid), 0);
    rd(A_IE, d);  chk("R11 ie", d, 0);
    rd(A_IP, d);  chk("R11 ip", d, 0);
    rd(A_DIV, d); chk("R11 div", d, 0);
    rd(A_RXD, d); chk("R11 fifo empty", d, 32'h8000_0000);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_TXC, 32'h0007_0000); rd(A_TXC, d); chk("R7 txctrl", d, 32'h0007_0000);
    wr(A_RXC, 32'h1234_5678); rd(A_RXC, d); chk("R7 rxctrl", d, 32'h1234_5678);
    wr(A_DIV, 32'hDEAD_BEEF); rd(A_DIV, d); chk("R7 div", d, 32'hDEAD_BEEF);
    wr(A_IE, 32'hFFFF_FFFC);  rd(A_IE, d);  chk("R7 ie", d, 32'hFFFF_FFFC);
    chk("R6 irq with both enables clear", 32'(irq), 0);
    wr(A_IE, 0); wr(A_TXC, 0); wr(A_RXC, 0);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    wr(A_TXD, 32'hABCD_1234);
    chk("R3 tx_valid", 32'(tx_valid), 1);
    chk("R3 tx_data", 32'(tx_data), 32'h34);
    @(negedge clk);
    chk("R3 tx pulse ends", 32'(tx_valid), 0);
    rd(A_TXD, d); chk("R3 txdata reads 0", d, 0);
  endtask

  task automatic t_txwm();
    logic [31:0] d;
    rd(A_IP, d); chk("R5 tx mark zero", d & 1, 0);
    wr(A_TXC, 32'h0001_0000);
    rd(A_IP, d); chk("R5 tx mark nonzero", d & 1, 1);
    wr(A_TXC, 32'hFFF8_FFFF);
    rd(A_IP, d); chk("R5 only bits 18:16 count", d & 1, 0);
    wr(A_TXC, 0);
  endtask

  task automatic t_fifo();
    logic [31:0] d;
    push(8'h11); push(8'h22); push(8'h33);
    wr(A_RXC, 32'h0002_0000);
    rd(A_IP, d); chk("R4 3 > 2", d & 2, 2);
    wr(A_RXC, 32'h0003_0000);
    rd(A_IP, d); chk("R4 3 > 3 false", d & 2, 0);
    wr(A_RXC, 0);
    rd(A_RXD, d); chk("R1 pop 1", d, 32'h11);
    rd(A_RXD, d); chk("R1 pop 2", d, 32'h22);
    rd(A_RXD, d); chk("R1 pop 3", d, 32'h33);
    rd(A_RXD, d); chk("R2 empty", d, 32'h8000_0000);
    rd(A_RXD, d); chk("R2 empty again", d, 32'h8000_0000);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(A_IE, 2);  chk("R6 rx enable, empty", 32'(irq), 0);
    push(8'h5A);  chk("R6 rx enable, one byte", 32'(irq), 1);
    rd(A_RXD, d); chk("R6 popped byte", d, 32'h5A);
    chk("R6 rx enable, drained", 32'(irq), 0);
    wr(A_IE, 1);  chk("R6 tx enable", 32'(irq), 1);
    wr(A_IE, 0);  chk("R6 none enabled", 32'(irq), 0);
  endtask

  task automatic t_full();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) push(8'hA0 + 8'(i));
    chk("R8 rx_ready low when full", 32'(rx_ready), 0);
    push(8'hFF);
    for (int i = 0; i < 8; i++) begin
      rd(A_RXD, d); chk("R8 kept order", d, 32'hA0 + i);
    end
    rd(A_RXD, d); chk("R8 extra byte dropped", d, 32'h8000_0000);
    chk("R8 rx_ready back", 32'(rx_ready), 1);
  endtask

  task automatic t_simul();
    logic [31:0] d;
    push(8'h50); push(8'h51);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = A_RXD; req_be = 4'hF;
    rx_valid = 1; rx_data = 8'h52;
    @(negedge clk);
    d = rsp_rdata; idle_bus(); rx_valid = 0;
    chk("R10 pop during push", d, 32'h50);
    rd(A_RXD, d); chk("R10 next", d, 32'h51);
    rd(A_RXD, d); chk("R10 pushed byte kept", d, 32'h52);
    rd(A_RXD, d); chk("R10 empty after", d, 32'h8000_0000);
  endtask

  task automatic t_bad();
    logic [31:0] d;
    wr(A_IE, 32'h3, 4'h3);
    chk("R9 partial write no irq", 32'(irq), 0);
    rd(A_IE, d); chk("R9 partial write ignored", d, 0);
    push(8'h77);
    rd(A_RXD, d, 4'h1); chk("R9 partial read returns 0", d, 0);
    rd(A_RXD, d); chk("R9 partial read did not pop", d, 32'h77);
    wr(A_DIV, 32'h0000_00AA);
    wr(A_BAD, 32'hFFFF_FFFF);
    rd(A_BAD, d); chk("R9 unmapped read", d, 0);
    rd(A_DIV, d); chk("R9 unmapped write ignored", d, 32'h0000_00AA);
    rd(A_IE, d);  chk("R9 unmapped write ignored ie", d, 0);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_bus();
    rx_valid = 0; rx_data = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_tx();
    t_txwm();
    t_fifo();
    t_irq();
    t_full();
    t_simul();
    t_bad();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule